// File: doc/BRIEF.md
# Qualified Non-Maskable Interrupt Detector

This block turns a raw, possibly noisy, non-maskable interrupt line into a clean request for the processor core. It first brings the line into the core clock domain. It then waits for an inactive-to-active transition. After that edge, the line has to stay active for a programmable number of clock cycles before the event counts as genuine. An edge that collapses before the window closes is thrown away, and a saturating counter records it so that software or a debug probe can see how noisy the line is.

A qualified event is held internally until the core signals an instruction boundary. At that point the request output rises. It stays high until the core acknowledges it. There is no enable or mask input of any kind, so a qualified event always leads to a request. Events that qualify while a request is already outstanding are folded into that request. A new request needs a fresh low-to-high transition of the line.

Top module: `nmi_qualifier`

## Requirements
- R1: While reset is low at a clock edge, `nmi_req` and `glitch_cnt` become 0, and both read 0 once reset is released.
- R2: With `qual_len` = L > 0, a raw active-high pulse that is sampled high on at least L+1 consecutive rising clock edges, following a low sample, produces exactly one qualified event.
- R3: A raw pulse sampled high on 1 to L consecutive edges (L > 0) produces no request and raises `glitch_cnt` by exactly one.
- R4: With `qual_len` = 0, every low-to-high transition that is sampled high on at least one edge qualifies.
- R5: `qual_len` is captured on the cycle the synchronized edge is seen. Changing it while that candidate is being timed does not alter the outcome.
- R6: A qualified event does not drive `nmi_req` high until `boundary_stb` is sampled high. `nmi_req` then rises on that same clock edge.
- R7: Once high, `nmi_req` stays high until `ack` is sampled high, and it falls on that edge.
- R8: An event that qualifies while `nmi_req` is high is merged into it. After the acknowledge, a later `boundary_stb` raises no second request.
- R9: `ack` sampled while `nmi_req` is low has no effect. A qualified event still waiting for a boundary survives it.
- R10: `glitch_cnt` saturates at 2^GLITCH_W-1 and holds there on further rejected candidates.
- R11: A line that stays active after the acknowledge raises no further request. A new request needs the line to return low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_raw | input | 1 | Asynchronous interrupt line, active high |
| boundary_stb | input | 1 | One-cycle strobe marking an instruction boundary |
| ack | input | 1 | Acknowledge from the core, clears the request |
| qual_len | input | QUAL_W | Cycles the line must stay active after the edge |
| nmi_req | output | 1 | Latched interrupt request to the core |
| glitch_cnt | output | GLITCH_W | Saturating count of rejected candidates |

## Verification
The bench builds the block with QUAL_W = 8, GLITCH_W = 3 and two synchronizer stages. An 8-bit length lets it probe both ends of the window, zero and 255, on each side of the L+1 threshold. A 3-bit counter reaches saturation after only seven rejections, so the hold-at-maximum case falls within a short run. Changing `qual_len` in the middle of a window checks the capture-at-edge rule in both directions. Overlapping events with the acknowledge check merging and re-arming.

// File: rtl/nmi_qual_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the qualified NMI detector.
// Assumes: nothing beyond IEEE 1800-2017.
package nmi_qual_pkg;

    // Qualifier states: waiting for an edge, or timing an active window.
    typedef enum logic [0:0] {
        QS_IDLE  = 1'b0,
        QS_COUNT = 1'b1
    } qual_state_t;

endpackage

// File: rtl/nmi_sync.sv
`timescale 1ns/1ps
// Module: nmi_sync
// Brings the asynchronous line into the clock domain through a flop chain.
// It also keeps a one-cycle-delayed copy so that edges can be found.
// Assumes: STAGES >= 2; the line is idle (low) during reset.
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic dout_prev
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First capture of the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_prev <= 1'b0;
        else        dout_prev <= chain[STAGES-1];
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/nmi_qual_fsm.sv
`timescale 1ns/1ps
// Module: nmi_qual_fsm
// Finds a rising edge on the synchronized line and then checks that the line
// stays high for the captured number of cycles. It emits one qual_ok pulse
// on success and one qual_fail pulse when the line drops too early.
// Assumes: lvl/lvl_prev come from nmi_sync; qual_len is sampled only at the edge.
module nmi_qual_fsm
    import nmi_qual_pkg::*;
#(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              lvl_prev,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              qual_ok,
    output logic              qual_fail
);

    qual_state_t       state_q, state_d;
    logic [QUAL_W-1:0] cnt_q, cnt_d;
    logic [QUAL_W-1:0] lim_q, lim_d;
    logic              rise;

    assign rise = lvl & ~lvl_prev;

    // Next-state and pulse decode for edge and window timing.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        lim_d     = lim_q;
        qual_ok   = 1'b0;
        qual_fail = 1'b0;
        unique case (state_q)
            QS_IDLE: begin
                if (rise) begin
                    if (qual_len == '0) begin
                        qual_ok = 1'b1;
                    end else begin
                        state_d = QS_COUNT;
                        lim_d   = qual_len;
                        cnt_d   = QUAL_W'(1);
                    end
                end
            end
            QS_COUNT: begin
                if (!lvl) begin
                    qual_fail = 1'b1;
                    state_d   = QS_IDLE;
                end else if (cnt_q == lim_q) begin
                    qual_ok = 1'b1;
                    state_d = QS_IDLE;
                end else begin
                    cnt_d = cnt_q + QUAL_W'(1);
                end
            end
            default: state_d = QS_IDLE;
        endcase
    end

    // State, window counter and captured limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QS_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

endmodule

// File: rtl/nmi_req_latch.sv
`timescale 1ns/1ps
// Module: nmi_req_latch
// Holds a qualified event until an instruction boundary. It then raises the
// request and keeps it up until acknowledged. Events arriving while the
// request is up are merged into it. There is no mask path.
// Assumes: qual_ok is a single-cycle pulse.
module nmi_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_ok,
    input  logic boundary_stb,
    input  logic ack,
    output logic pend,
    output logic req
);

    logic req_d;
    logic pend_d;

    // Request update: present at a boundary, drop on acknowledge.
    always_comb begin
        if (req) req_d = ~ack;
        else     req_d = pend & boundary_stb;
    end

    // Waiting flag: set by an unmerged event, cleared when presented.
    always_comb begin
        if (req_d && !req) pend_d = 1'b0;
        else               pend_d = pend | (qual_ok & ~req);
    end

    // Request and waiting-event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            pend <= 1'b0;
        end else begin
            req  <= req_d;
            pend <= pend_d;
        end
    end

endmodule

// File: rtl/nmi_sat_counter.sv
`timescale 1ns/1ps
// Module: nmi_sat_counter
// Up-counter that stops at its all-ones value.
// Assumes: inc is a single-cycle pulse per event.
module nmi_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = '1;

    // Count events, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count <= '0;
        else if (inc && count != CNT_MAX)  count <= count + W'(1);
    end

endmodule

// File: rtl/nmi_qualifier.sv
`timescale 1ns/1ps
// Module: nmi_qualifier (top)
// Synchronizes the raw NMI line, qualifies edges by minimum active duration,
// and presents the request at instruction boundaries until acknowledged.
// Rejected candidates are counted in a saturating status field.
// Assumes: boundary_stb and ack are synchronous to clk; qual_len is quasi-static.
module nmi_qualifier #(
    parameter int QUAL_W      = 8,
    parameter int GLITCH_W    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_raw,
    input  logic                boundary_stb,
    input  logic                ack,
    input  logic [QUAL_W-1:0]   qual_len,
    output logic                nmi_req,
    output logic [GLITCH_W-1:0] glitch_cnt
);

    logic lvl;
    logic lvl_prev;
    logic qual_ok;
    logic qual_fail;
    logic pend;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (nmi_raw),
        .dout      (lvl),
        .dout_prev (lvl_prev)
    );

    nmi_qual_fsm #(.QUAL_W(QUAL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .lvl_prev  (lvl_prev),
        .qual_len  (qual_len),
        .qual_ok   (qual_ok),
        .qual_fail (qual_fail)
    );

    nmi_req_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .qual_ok      (qual_ok),
        .boundary_stb (boundary_stb),
        .ack          (ack),
        .pend         (pend),
        .req          (nmi_req)
    );

    nmi_sat_counter #(.W(GLITCH_W)) u_glitch (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (qual_fail),
        .count (glitch_cnt)
    );

endmodule

// File: rtl/nmi_qualifier_chk.sv
`timescale 1ns/1ps
// Module: nmi_qualifier_chk
// Temporal checks on the detector, bound into every nmi_qualifier instance.
// Assumes: connected to the top-level nets named in the bind below.
module nmi_qualifier_chk #(
    parameter int GLITCH_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                boundary_stb,
    input logic                ack,
    input logic                nmi_req,
    input logic [GLITCH_W-1:0] glitch_cnt,
    input logic                qual_ok,
    input logic                qual_fail,
    input logic                pend
);

    localparam logic [GLITCH_W-1:0] GMAX = '1;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req && !ack |=> nmi_req); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req && ack |=> !nmi_req); // R7
    AST_RISE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(boundary_stb) && $past(pend)); // R6
    AST_FAIL_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        qual_fail && glitch_cnt != GMAX |=> glitch_cnt == GLITCH_W'($past(glitch_cnt) + 1'b1)); // R3
    AST_COUNT_ONLY_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_fail |=> $stable(glitch_cnt)); // R3
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_cnt == GMAX |=> glitch_cnt == GMAX); // R10
    AST_OK_FAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(qual_ok && qual_fail)); // R2
    AST_MERGE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req && qual_ok |=> !pend); // R8

endmodule

bind nmi_qualifier nmi_qualifier_chk #(.GLITCH_W(GLITCH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_stb (boundary_stb),
    .ack          (ack),
    .nmi_req      (nmi_req),
    .glitch_cnt   (glitch_cnt),
    .qual_ok      (qual_ok),
    .qual_fail    (qual_fail),
    .pend         (pend)
);

// File: tb/sim_nmi_qualifier.sv
`timescale 1ns/1ps
module sim_nmi_qualifier;

    localparam int QW = 8;
    localparam int GW = 3;
    localparam int GMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_raw = 1'b0;
    logic          boundary_stb = 1'b0;
    logic          ack = 1'b0;
    logic [QW-1:0] qual_len = '0;
    logic          nmi_req;
    logic [GW-1:0] glitch_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_g = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nmi_qualifier #(.QUAL_W(QW), .GLITCH_W(GW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_raw(nmi_raw), .boundary_stb(boundary_stb),
        .ack(ack), .qual_len(qual_len), .nmi_req(nmi_req), .glitch_cnt(glitch_cnt)
    );

    // Vector: {qual_len[8], high cycles[16], qualifies[1]}
    localparam logic [24:0] VEC [10] = '{
        {8'd0,   16'd1,   1'b1},   // R4
        {8'd3,   16'd3,   1'b0},   // R3
        {8'd3,   16'd4,   1'b1},   // R2
        {8'd5,   16'd2,   1'b0},
        {8'd1,   16'd2,   1'b1},
        {8'd1,   16'd1,   1'b0},
        {8'd10,  16'd20,  1'b1},
        {8'd255, 16'd255, 1'b0},
        {8'd255, 16'd256, 1'b1},
        {8'd2,   16'd40,  1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int h);
        nmi_raw = 1'b1;
        cyc(h);
        nmi_raw = 1'b0;
        cyc(6);
    endtask

    task automatic strobe();
        boundary_stb = 1'b1;
        cyc(1);
        boundary_stb = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic note_fail();
        if (exp_g < GMAX) exp_g++;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R1 req at reset", int'(nmi_req), 0);
        chk("R1 glitch at reset", int'(glitch_cnt), 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 req after release", int'(nmi_req), 0);

        // Table walk: R2/R3/R4/R6/R7
        for (int i = 0; i < 10; i++) begin
            qual_len = VEC[i][24:17];
            pulse(int'(VEC[i][16:1]));
            if (!VEC[i][0]) note_fail();
            chk("R3 glitch count", int'(glitch_cnt), exp_g);
            chk("R6 no req before boundary", int'(nmi_req), 0);
            strobe();
            chk("R2 req after boundary", int'(nmi_req), int'(VEC[i][0]));
            cyc(3);
            chk("R7 req held", int'(nmi_req), int'(VEC[i][0]));
            do_ack();
            chk("R7 req cleared by ack", int'(nmi_req), 0);
        end

        // R5: length captured at edge (short captured, raised later)
        qual_len = 8'd2;
        nmi_raw = 1'b1;
        cyc(3);
        qual_len = 8'd200;
        nmi_raw = 1'b0;
        cyc(6);
        strobe();
        chk("R5 short capture qualifies", int'(nmi_req), 1);
        do_ack();
        // R5: long captured, lowered later
        qual_len = 8'd200;
        nmi_raw = 1'b1;
        cyc(3);
        qual_len = 8'd1;
        nmi_raw = 1'b0;
        cyc(6);
        note_fail();
        strobe();
        chk("R5 long capture rejects", int'(nmi_req), 0);
        chk("R5 glitch count", int'(glitch_cnt), exp_g);

        // R9: ack while idle does not lose a waiting event
        qual_len = 8'd0;
        pulse(1);
        do_ack();
        chk("R9 ack idle keeps req low", int'(nmi_req), 0);
        strobe();
        chk("R9 event survives stray ack", int'(nmi_req), 1);
        do_ack();

        // R8: merge while request is up
        pulse(1);
        strobe();
        chk("R8 first request", int'(nmi_req), 1);
        pulse(1);
        chk("R8 still single request", int'(nmi_req), 1);
        do_ack();
        strobe();
        chk("R8 merged event not re-raised", int'(nmi_req), 0);

        // R11: line stays high across ack
        nmi_raw = 1'b1;
        cyc(6);
        strobe();
        chk("R11 request from held line", int'(nmi_req), 1);
        do_ack();
        cyc(10);
        strobe();
        chk("R11 no re-raise while held", int'(nmi_req), 0);
        nmi_raw = 1'b0;
        cyc(4);
        pulse(1);
        strobe();
        chk("R11 new edge raises", int'(nmi_req), 1);
        do_ack();

        // R10: saturation
        qual_len = 8'd4;
        for (int k = 0; k < 9; k++) begin
            pulse(1);
            note_fail();
        end
        chk("R10 saturated count", int'(glitch_cnt), GMAX);
        pulse(2);
        chk("R10 holds at max", int'(glitch_cnt), GMAX);

        // R1: reset mid-operation
        qual_len = 8'd0;
        pulse(1);
        strobe();
        chk("R1 req before reset", int'(nmi_req), 1);
        rst_n = 1'b0;
        cyc(2);
        chk("R1 req cleared by reset", int'(nmi_req), 0);
        chk("R1 glitch cleared by reset", int'(glitch_cnt), 0);
        rst_n = 1'b1;
        cyc(2);

        finish_run();
    end

endmodule